// File: doc/BRIEF.md
# Teletext Bit Request and Insertion Window Controller

This block fetches a serial teletext bitstream from an external source, one bit per request, and hands the bits on to a downstream interpolator. At the start of each video line it checks whether teletext is enabled and whether the line lies in the line range programmed for the current field. The odd field and the even field each have their own first/last pair. On a selected line it opens an insertion window at a programmable horizontal position. While the window is open it issues one single-clock request pulse per bit. The pulses come from a fractional phase accumulator that runs at the teletext bit rate relative to the 27 MHz line-locked clock. The window closes once the mode's bit count has been requested.

The source answers each request with one bit after a programmable latency of 0 to 15 clocks. The block samples the input exactly that many clocks after each request and presents the bit with a one-cycle valid strobe. Three modes are supported, each with its own window length and bit rate: a 625-line world-system mode, a 525-line world-system mode, and a North American broadcast mode.

Top module: `ttx_window_ctrl`

## Requirements
- R1: After reset, `ttx_req`, `bit_valid` and `win_open` are all low.
- R2: A window can open on a line only if `tx_enable` is 1, `mode` is not 3, and `line_num` lies inside the inclusive range for the field. The range is `odd_first..odd_last` when `field_odd`=1 and `even_first..even_last` when `field_odd`=0. All of these are sampled in the cycle where `line_start` is high. Otherwise no request is issued on that line.
- R3: If `line_start` is high in cycle T on a selected line, the k-th request (k from 0) is high in cycle T+3+`req_pos`+ceil(k·D/N). N/D is 37/144 in mode 0 (6.9375 Mbit/s) and 7/33 in modes 1 and 2 (about 5.727 Mbit/s).
- R4: Every request pulse is exactly one clock wide.
- R5: A selected line carries exactly 360 requests in mode 0, 296 in mode 1 and 288 in mode 2. After that `win_open` is low and no further request occurs on that line.
- R6: For a request high in cycle C with latency L=`data_lat`, `bit_valid` is high in cycle C+L+1 and `bit_out` then equals the `ttx_in` value of cycle C+L. Every request yields exactly one valid bit, in order.
- R7: A `line_start` pulse closes any open window. No request issued in a later cycle belongs to the old line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz line-locked clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the outgoing horizontal sync leading edge |
| line_num | input | 10 | Line number within the current field |
| field_odd | input | 1 | 1 = odd field, 0 = even field |
| tx_enable | input | 1 | Teletext insertion enable |
| mode | input | 2 | 0 = 625-line world system, 1 = 525-line world system, 2 = North American broadcast, 3 = reserved (no window) |
| req_pos | input | 11 | Clocks from line start to window opening |
| data_lat | input | 4 | Source latency from request to valid data, in clocks |
| odd_first | input | 10 | First selected line, odd field |
| odd_last | input | 10 | Last selected line, odd field |
| even_first | input | 10 | First selected line, even field |
| even_last | input | 10 | Last selected line, even field |
| ttx_in | input | 1 | Serial teletext data from the source |
| ttx_req | output | 1 | Bit request pulse to the source |
| bit_out | output | 1 | Captured teletext bit |
| bit_valid | output | 1 | Strobe marking a new `bit_out` |
| win_open | output | 1 | Insertion window is open |

## Verification
On every cycle, the assertions enforce several properties. Request pulses are single-cycle. The bit counter stays below the mode's count while the window is open. A line start closes the window. A disabled or reserved-mode line never arms. Valid strobes are single-cycle while the latency is steady. The exact pulse positions set by the fractional accumulator, the total per mode, and the pairing of each valid bit with the source data at the latency-shifted cycle are shown only by the bench's line scenarios. The same holds for the range boundaries of each field and the truncation of a cut-short line.

// File: rtl/ttx_win_pkg.sv
package ttx_win_pkg;

  typedef enum logic [1:0] {
    MODE_W625 = 2'd0,
    MODE_W525 = 2'd1,
    MODE_NAB  = 2'd2,
    MODE_RSVD = 2'd3
  } ttx_mode_e;

  localparam int CNT_W = 9;
  localparam int ACC_W = 8;

  localparam int W625_BITS = 360;
  localparam int W525_BITS = 296;
  localparam int NAB_BITS  = 288;

  // bit rate / 27 MHz as numerator over denominator
  localparam int W625_NUM = 37;
  localparam int W625_DEN = 144;
  localparam int SLOW_NUM = 7;
  localparam int SLOW_DEN = 33;

  function automatic logic [CNT_W-1:0] mode_bits(ttx_mode_e m);
    case (m)
      MODE_W625: mode_bits = CNT_W'(W625_BITS);
      MODE_W525: mode_bits = CNT_W'(W525_BITS);
      default:   mode_bits = CNT_W'(NAB_BITS);
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] mode_num(ttx_mode_e m);
    mode_num = (m == MODE_W625) ? ACC_W'(W625_NUM) : ACC_W'(SLOW_NUM);
  endfunction

  function automatic logic [ACC_W-1:0] mode_den(ttx_mode_e m);
    mode_den = (m == MODE_W625) ? ACC_W'(W625_DEN) : ACC_W'(SLOW_DEN);
  endfunction

endpackage

// File: rtl/ttx_line_gate.sv
module ttx_line_gate
  import ttx_win_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int HPOS_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_odd,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [HPOS_W-1:0] req_pos,
  input  logic [LINE_W-1:0] odd_first,
  input  logic [LINE_W-1:0] odd_last,
  input  logic [LINE_W-1:0] even_first,
  input  logic [LINE_W-1:0] even_last,
  output logic              open_go,
  output ttx_mode_e         mode_q
);

  logic [HPOS_W-1:0] hcnt_q, hcnt_d;
  logic              armed_q, armed_d;
  ttx_mode_e         mode_d;
  logic              in_rng;

  always_comb begin
    if (field_odd) in_rng = (line_num >= odd_first) && (line_num <= odd_last);
    else           in_rng = (line_num >= even_first) && (line_num <= even_last);

    open_go = armed_q && (hcnt_q == req_pos) && !line_start;

    hcnt_d = hcnt_q;
    if (line_start)          hcnt_d = '0;
    else if (hcnt_q != '1)   hcnt_d = hcnt_q + HPOS_W'(1);

    armed_d = armed_q;
    mode_d  = mode_q;
    if (line_start) begin
      armed_d = enable && in_rng && (ttx_mode_e'(mode) != MODE_RSVD);
      mode_d  = ttx_mode_e'(mode);
    end else if (open_go) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      armed_q <= 1'b0;
      mode_q  <= MODE_W625;
    end else begin
      hcnt_q  <= hcnt_d;
      armed_q <= armed_d;
      mode_q  <= mode_d;
    end
  end

  // R2: a disabled line never arms
  a_r2_disabled_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !enable) |=> !armed_q);
  // R2: reserved mode never arms
  a_r2_rsvd_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && (mode == 2'd3)) |=> !armed_q);
  // R2: one window per line
  a_r2_open_once: assert property (@(posedge clk) disable iff (!rst_n)
    open_go |=> !armed_q);

endmodule

// File: rtl/ttx_rate_gen.sv
module ttx_rate_gen
  import ttx_win_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_start,
  input  logic      open_go,
  input  ttx_mode_e mode_q,
  output logic      req,
  output logic      win
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             win_d, req_d;
  logic [ACC_W:0]   acc_sum;
  logic [ACC_W-1:0] num, den;
  logic [CNT_W-1:0] nbits;
  logic             fire;

  always_comb begin
    num     = mode_num(mode_q);
    den     = mode_den(mode_q);
    nbits   = mode_bits(mode_q);
    acc_sum = {1'b0, acc_q} + {1'b0, num};
    fire    = win && (acc_sum >= {1'b0, den});

    acc_d = acc_q;
    cnt_d = cnt_q;
    win_d = win;
    req_d = 1'b0;
    if (line_start) begin
      win_d = 1'b0;
    end else if (open_go) begin
      win_d = 1'b1;
      acc_d = den - num;          // first step fires at once
      cnt_d = '0;
    end else if (win) begin
      req_d = fire;
      if (fire) begin
        acc_d = ACC_W'(acc_sum - {1'b0, den});
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q + CNT_W'(1) == nbits) win_d = 1'b0;
      end else begin
        acc_d = acc_sum[ACC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      win   <= 1'b0;
      req   <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      win   <= win_d;
      req   <= req_d;
    end
  end

  // R4: requests are single-cycle
  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R5: counter never reaches the mode total while open
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> (cnt_q < nbits));
  // R7: a line start closes the window and stops requests
  a_r7_line_closes: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (!win && !req));

endmodule

// File: rtl/ttx_capture.sv
module ttx_capture #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LAT_W-1:0] lat,
  input  logic             ttx_in,
  output logic             bit_out,
  output logic             bit_valid
);

  localparam int DEPTH = 1 << LAT_W;

  logic [DEPTH-2:0] req_sh_q, req_sh_d;
  logic [DEPTH-1:0] taps;
  logic             strobe;
  logic             bit_d;

  always_comb begin
    taps     = {req_sh_q, req};
    strobe   = taps[lat];
    req_sh_d = {req_sh_q[DEPTH-3:0], req};
    bit_d    = strobe ? ttx_in : bit_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sh_q  <= '0;
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      req_sh_q  <= req_sh_d;
      bit_out   <= bit_d;
      bit_valid <= strobe;
    end
  end

  // R6: with a steady latency each request gives one single-cycle strobe
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> (!bit_valid || !$stable(lat)));

endmodule

// File: rtl/ttx_window_ctrl.sv
module ttx_window_ctrl
  import ttx_win_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int HPOS_W = 11,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_odd,
  input  logic              tx_enable,
  input  logic [1:0]        mode,
  input  logic [HPOS_W-1:0] req_pos,
  input  logic [LAT_W-1:0]  data_lat,
  input  logic [LINE_W-1:0] odd_first,
  input  logic [LINE_W-1:0] odd_last,
  input  logic [LINE_W-1:0] even_first,
  input  logic [LINE_W-1:0] even_last,
  input  logic              ttx_in,
  output logic              ttx_req,
  output logic              bit_out,
  output logic              bit_valid,
  output logic              win_open
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       open_go;
  ttx_mode_e  mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ttx_line_gate #(.LINE_W(LINE_W), .HPOS_W(HPOS_W)) u_gate (
    .clk(clk), .rst_n(rst_int_n), .line_start(line_start), .line_num(line_num),
    .field_odd(field_odd), .enable(tx_enable), .mode(mode), .req_pos(req_pos),
    .odd_first(odd_first), .odd_last(odd_last), .even_first(even_first),
    .even_last(even_last), .open_go(open_go), .mode_q(mode_q)
  );

  ttx_rate_gen u_rate (
    .clk(clk), .rst_n(rst_int_n), .line_start(line_start), .open_go(open_go),
    .mode_q(mode_q), .req(ttx_req), .win(win_open)
  );

  ttx_capture #(.LAT_W(LAT_W)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .req(ttx_req), .lat(data_lat), .ttx_in(ttx_in),
    .bit_out(bit_out), .bit_valid(bit_valid)
  );

  // R1: outputs stay quiet while the internal reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> (!ttx_req && !bit_valid && !win_open));

endmodule

// File: tb/ttx_window_ctrl_bench.sv
module ttx_window_ctrl_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, line_start, field_odd, tx_enable, ttx_in;
  logic [9:0] line_num, odd_first, odd_last, even_first, even_last;
  logic [1:0] mode;
  logic [10:0] req_pos;
  logic [3:0] data_lat;
  logic       ttx_req, bit_out, bit_valid, win_open;

  ttx_window_ctrl u_ttx_window_ctrl (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .field_odd(field_odd), .tx_enable(tx_enable), .mode(mode), .req_pos(req_pos),
    .data_lat(data_lat), .odd_first(odd_first), .odd_last(odd_last),
    .even_first(even_first), .even_last(even_last), .ttx_in(ttx_in),
    .ttx_req(ttx_req), .bit_out(bit_out), .bit_valid(bit_valid), .win_open(win_open)
  );

  int unsigned cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  logic mon_en = 1'b0;
  logic done = 1'b0;
  int q_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic src_bit(int unsigned n);
    logic [31:0] h;
    h = n * 32'h9E3779B1;
    return h[17] ^ h[5];
  endfunction

  always @(negedge clk) ttx_in <= src_bit(cyc);

  function automatic int exp_total(logic [1:0] md);
    return (md == 2'd0) ? 360 : (md == 2'd1) ? 296 : 288;
  endfunction
  function automatic int exp_num(logic [1:0] md);
    return (md == 2'd0) ? 37 : 7;
  endfunction
  function automatic int exp_den(logic [1:0] md);
    return (md == 2'd0) ? 144 : 33;
  endfunction

  // R6 monitor: every valid bit pairs with the oldest request
  always @(negedge clk) begin
    if (mon_en) begin
      if (ttx_req) q_req.push_back(int'(cyc));
      if (bit_valid) begin
        n_chk++;
        if (q_req.size() == 0) begin
          n_bad++;
          $display("FAIL R6 valid without request: cycle=%0d expected none", cyc);
        end else begin
          int rc;
          rc = q_req.pop_front();
          if (int'(cyc) != rc + int'(data_lat) + 1 || bit_out != src_bit(cyc - 1)) begin
            n_bad++;
            $display("FAIL R6 valid cycle=%0d bit=%0b expected cycle=%0d bit=%0b",
                     cyc, bit_out, rc + int'(data_lat) + 1, src_bit(cyc - 1));
          end
        end
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // starts at a negedge; ends at the negedge of the cycle len after line start
  task automatic run_line(input logic [9:0] ln, input logic odd, input logic en,
                          input logic [1:0] md, input logic [10:0] sp,
                          input logic [3:0] lt, input int len, input string tag);
    int t0, nreq, nmis, first_bad, nexp, cnt_exp;
    int rc[400];
    logic act;
    line_num = ln; field_odd = odd; tx_enable = en; mode = md;
    req_pos = sp; data_lat = lt; line_start = 1'b1;
    t0 = int'(cyc);
    nreq = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) line_start = 1'b0;
      if (ttx_req && nreq < 400) begin rc[nreq] = int'(cyc); nreq++; end
    end
    act = en && (md != 2'd3) &&
          (odd ? (ln >= odd_first && ln <= odd_last) : (ln >= even_first && ln <= even_last));
    cnt_exp = 0;
    if (act) begin
      for (int k = 0; k < exp_total(md); k++) begin
        int c;
        c = t0 + 3 + int'(sp) + (k * exp_den(md) + exp_num(md) - 1) / exp_num(md);
        if (c <= t0 + len) cnt_exp++;
      end
    end
    // R2 / R5 / R7: number of requests on the line
    check(nreq == cnt_exp, {tag, " R5 request count"}, nreq, cnt_exp);
    nmis = 0; first_bad = -1;
    for (int k = 0; k < nreq && k < cnt_exp; k++) begin
      nexp = t0 + 3 + int'(sp) + (k * exp_den(md) + exp_num(md) - 1) / exp_num(md);
      if (rc[k] != nexp) begin
        if (first_bad < 0) first_bad = k;
        nmis++;
      end
    end
    // R3: request positions
    if (cnt_exp > 0) begin
      if (first_bad >= 0)
        check(1'b0, {tag, " R3 request cycle"}, rc[first_bad],
              t0 + 3 + int'(sp) + (first_bad * exp_den(md) + exp_num(md) - 1) / exp_num(md));
      else
        check(1'b1, {tag, " R3 request cycle"}, 0, 0);
    end
    // R5: window shut at line end when the full count fitted
    if (cnt_exp == exp_total(md) || cnt_exp == 0)
      check(win_open == 1'b0, {tag, " R5 window closed"}, int'(win_open), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; line_start = 1'b0; line_num = '0; field_odd = 1'b1;
    tx_enable = 1'b0; mode = 2'd0; req_pos = '0; data_lat = '0;
    odd_first = 10'd7; odd_last = 10'd22; even_first = 10'd320; even_last = 10'd335;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!ttx_req && !bit_valid && !win_open, "R1 reset outputs", int'({ttx_req, bit_valid, win_open}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!ttx_req && !bit_valid && !win_open, "R1 after release", int'({ttx_req, bit_valid, win_open}), 0);
    mon_en = 1'b1;

    // directed cases (R2 boundaries, all modes, latency extremes)
    run_line(10'd10,  1'b1, 1'b1, 2'd0, 11'd50,  4'd0,  1570, "d1 w625 lat0");
    run_line(10'd325, 1'b0, 1'b1, 2'd1, 11'd0,   4'd15, 1520, "d2 w525 lat15");
    run_line(10'd7,   1'b1, 1'b1, 2'd2, 11'd100, 4'd3,  1620, "d3 nab first line");
    run_line(10'd22,  1'b1, 1'b1, 2'd0, 11'd5,   4'd7,  1525, "d4 last odd line");
    run_line(10'd23,  1'b1, 1'b1, 2'd0, 11'd5,   4'd7,  300,  "d5 R2 past odd range");
    run_line(10'd10,  1'b0, 1'b1, 2'd0, 11'd5,   4'd7,  300,  "d6 R2 even field odd line");
    run_line(10'd335, 1'b0, 1'b0, 2'd1, 11'd5,   4'd7,  300,  "d7 R2 disabled");
    run_line(10'd12,  1'b1, 1'b1, 2'd3, 11'd5,   4'd7,  300,  "d8 R2 reserved mode");
    // R7: cut-short line, following line must stay silent
    run_line(10'd12,  1'b1, 1'b1, 2'd0, 11'd20,  4'd2,  400,  "d9 R7 cut line");
    run_line(10'd30,  1'b1, 1'b1, 2'd0, 11'd20,  4'd2,  200,  "d10 R7 after cut");

    // constrained random lines
    for (int n = 0; n < 14; n++) begin
      logic [9:0] ln; logic odd; logic en; logic [1:0] md; logic [10:0] sp; logic [3:0] lt;
      odd = 1'($urandom());
      if ($urandom_range(0, 1) == 0)
        ln = odd ? 10'($urandom_range(7, 22)) : 10'($urandom_range(320, 335));
      else
        ln = 10'($urandom_range(0, 400));
      en = ($urandom_range(0, 4) != 0);
      md = 2'($urandom_range(0, 3));
      sp = 11'($urandom_range(0, 150));
      lt = 4'($urandom());
      run_line(ln, odd, en, md, sp, lt, int'(sp) + 1520, "rand");
    end

    repeat (20) @(negedge clk);
    // R6: all requests answered
    check(q_req.size() == 0, "R6 pending requests", q_req.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule